// File: doc/BRIEF.md
# Strided Vector Load Engine

The engine fills one vector register from a banked main memory. A single start command carries a base word address, a signed stride and an element count, together with the number of the destination vector register. The engine steps through the element addresses `base + i*stride` and sends one read per cycle at most through a single memory request port. The memory answers each read a fixed number of cycles later, and the engine writes each returned word into the vector register at its element index.

Memory is made of `2^BANK_BITS` interleaved banks, and the low bits of the word address pick the bank. A bank that has accepted a read cannot take another for `BUSY_CYC` cycles. The engine keeps one down-counter per bank and holds issue while the bank of the next element is still counting. Elements always leave in index order, so a stride that keeps hitting a few banks slows the load and never reorders it. A completion pulse follows the last register write.

Top module: `strided_vload`

## Requirements
- R1: Element i is read from word address `(base + i*stride) mod 2^ADDR_W`. The stride is taken as two's complement, so a negative stride counts downward and addresses wrap at both ends.
- R2: A command with count n makes exactly n memory requests and n register writes. A count of 0 makes none and gives the completion pulse in the first cycle after the command.
- R3: The bank of an address is its low `BANK_BITS` bits. A bank that accepts a request in cycle t accepts none before cycle t+`BUSY_CYC`.
- R4: Requests go out in element order, at most one per cycle. The first one goes out in the cycle after the command is taken. Each later element goes out in the first cycle that is both after the previous request and free of its bank's busy time.
- R5: With stride 0, or any stride that is a multiple of the bank count, one element issues every `BUSY_CYC` cycles.
- R6: With an odd stride, the engine issues one element per cycle.
- R7: The word on `mem_rdata` returns `RD_LAT` cycles after its request. In that cycle it is written with `vr_we` high, `vr_idx` equal to its element index and `vr_sel` equal to the commanded register.
- R8: `done` is a one-cycle pulse in the cycle after the last register write. `busy` is high from the cycle after a non-empty command is taken until that pulse.
- R9: A start that comes while `busy` is high has no effect on the load in progress.
- R10: While reset is held and just after it, `busy`, `done`, `mem_req` and `vr_we` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Command strobe; taken only when not busy |
| start_base | input | ADDR_W | Word address of element 0 |
| start_stride | input | ADDR_W | Step between elements, two's complement |
| start_len | input | LEN_W | Element count, 0 to VLEN_MAX |
| start_vd | input | VD_W | Destination vector register |
| busy | output | 1 | A load is in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Read request this cycle |
| mem_addr | output | ADDR_W | Word address of the request |
| mem_rdata | input | DATA_W | Read word, valid RD_LAT cycles after its request |
| vr_we | output | 1 | Vector register write strobe |
| vr_sel | output | VD_W | Vector register being written |
| vr_idx | output | IDX_W | Element index of the write |
| vr_wdata | output | DATA_W | Word written |

## Verification
The bench builds the engine with a 12-bit address, 16 banks, a 4-cycle bank busy time, a 3-cycle read latency and 16-element registers. The narrow address lets a few elements cross the top of memory going up and going down. With 16 elements and a 4-cycle busy time, every stride pattern shows its own pace within one load: full rate for odd strides, no stall for strides of 2 and 4, paired stalls for stride 8, and one element per bank time for strides 0 and 16. The scoreboard predicts the cycle of every write from a model of the bank timers, so a stall that is one cycle too early or too late shows up as a failed check.

// File: rtl/vld_pkg.sv
// Shared types for the strided vector load engine.
// Assumes: nothing beyond the IEEE 1800-2017 language.
package vld_pkg;
    // Phase of a load: idle, still sending requests, or waiting for the last returns.
    typedef enum logic [1:0] {
        VL_IDLE  = 2'd0,
        VL_ISSUE = 2'd1,
        VL_DRAIN = 2'd2
    } vl_phase_e;
endpackage

// File: rtl/vld_bank_timers.sv
// One busy down-counter per memory bank. A request into a bank loads its
// counter so the bank reads free again exactly BUSY_CYC cycles later.
// Assumes: at most one request per cycle, and only into a free bank.
module vld_bank_timers #(
    parameter int NBANK    = 16,
    parameter int BANK_W   = 4,
    parameter int BUSY_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              iss,
    input  logic [BANK_W-1:0] iss_bank,
    output logic [NBANK-1:0]  bank_free
);
    localparam int TW = (BUSY_CYC > 1) ? $clog2(BUSY_CYC) : 1;
    localparam logic [TW-1:0] RELOAD = TW'(BUSY_CYC - 1);

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic [TW-1:0] cnt_q;

        // Load the bank's counter on a request to it, otherwise count down to zero.
        always_ff @(posedge clk) begin
            if (!rst_n)
                cnt_q <= '0;
            else if (iss && (iss_bank == BANK_W'(b)))
                cnt_q <= RELOAD;
            else if (cnt_q != '0)
                cnt_q <= cnt_q - 1'b1;
        end

        assign bank_free[b] = (cnt_q == '0);

        if (BUSY_CYC > 1) begin : g_hold
            // R3: a bank just hit is not free in the next cycle
            a_r3_bank_hold: assert property (@(posedge clk) disable iff (!rst_n)
                (iss && (iss_bank == BANK_W'(b))) |=> !bank_free[b]);
            // R3: a counting bank takes no request
            a_r3_no_hit_busy: assert property (@(posedge clk) disable iff (!rst_n)
                (!bank_free[b]) |-> !(iss && (iss_bank == BANK_W'(b))));
        end
    end
endmodule

// File: rtl/vld_addr_gen.sv
// Element address and index generator. Holds the current address and
// element index. A load sets them to base and 0, and each advance adds the
// stride (modulo 2^ADDR_W) and bumps the index.
// Assumes: load and advance never arrive in the same cycle.
module vld_addr_gen #(
    parameter int ADDR_W = 16,
    parameter int LEN_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] stride,
    input  logic              adv,
    output logic [ADDR_W-1:0] addr,
    output logic [LEN_W-1:0]  idx
);
    logic [ADDR_W-1:0] stride_q;

    // Keep the stride of the running command.
    always_ff @(posedge clk) begin
        if (!rst_n)
            stride_q <= '0;
        else if (load)
            stride_q <= stride;
    end

    // Step the address by the stride; the sum wraps at the address width.
    always_ff @(posedge clk) begin
        if (!rst_n)
            addr <= '0;
        else if (load)
            addr <= base;
        else if (adv)
            addr <= addr + stride_q;
    end

    // Count elements sent so far.
    always_ff @(posedge clk) begin
        if (!rst_n)
            idx <= '0;
        else if (load)
            idx <= '0;
        else if (adv)
            idx <= idx + 1'b1;
    end

    // R1: each advance moves the address by exactly one stride
    a_r1_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !load) |=> (addr == $past(addr) + $past(stride_q)));
    // R4: the element index moves by one per advance
    a_r4_idx_step: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !load) |=> (idx == $past(idx) + 1'b1));
endmodule

// File: rtl/vld_resp_pipe.sv
// Tag pipeline matching the fixed memory read latency. It carries a valid
// bit and the element index of each request for RD_LAT cycles, so the tag
// comes out in the same cycle as the memory's word.
// Assumes: RD_LAT is at least 1.
module vld_resp_pipe #(
    parameter int RD_LAT = 3,
    parameter int IDX_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_v,
    input  logic [IDX_W-1:0] in_idx,
    output logic             out_v,
    output logic [IDX_W-1:0] out_idx
);
    logic             v_q   [RD_LAT];
    logic [IDX_W-1:0] idx_q [RD_LAT];

    for (genvar s = 0; s < RD_LAT; s++) begin : g_stage
        if (s == 0) begin : g_head
            // Capture the tag of the request sent this cycle.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    v_q[0]   <= 1'b0;
                    idx_q[0] <= '0;
                end else begin
                    v_q[0]   <= in_v;
                    idx_q[0] <= in_idx;
                end
            end
        end else begin : g_body
            // Move the tag one stage along.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    v_q[s]   <= 1'b0;
                    idx_q[s] <= '0;
                end else begin
                    v_q[s]   <= v_q[s-1];
                    idx_q[s] <= idx_q[s-1];
                end
            end
        end
    end

    assign out_v   = v_q[RD_LAT-1];
    assign out_idx = idx_q[RD_LAT-1];
endmodule

// File: rtl/strided_vload.sv
// Strided vector load engine, top level. It takes a command (base, stride,
// count, destination register), sends one read per cycle at most in element
// order, and holds issue while the bank of the next element is busy. Each
// returned word is written to the destination register at its element index.
// Assumes: memory returns every word exactly RD_LAT cycles after its request,
// and RD_LAT >= 1.
module strided_vload #(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 64,
    parameter int BANK_BITS = 4,
    parameter int BUSY_CYC  = 4,
    parameter int RD_LAT    = 3,
    parameter int VLEN_MAX  = 16,
    parameter int NUM_VREG  = 8,
    localparam int NBANK    = 1 << BANK_BITS,
    localparam int LEN_W    = $clog2(VLEN_MAX + 1),
    localparam int IDX_W    = (VLEN_MAX > 1) ? $clog2(VLEN_MAX) : 1,
    localparam int VD_W     = (NUM_VREG > 1) ? $clog2(NUM_VREG) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_base,
    input  logic [ADDR_W-1:0] start_stride,
    input  logic [LEN_W-1:0]  start_len,
    input  logic [VD_W-1:0]   start_vd,
    output logic              busy,
    output logic              done,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              vr_we,
    output logic [VD_W-1:0]   vr_sel,
    output logic [IDX_W-1:0]  vr_idx,
    output logic [DATA_W-1:0] vr_wdata
);
    import vld_pkg::*;

    vl_phase_e          phase_q;
    logic [LEN_W-1:0]   len_q;
    logic [VD_W-1:0]    vd_q;
    logic [LEN_W-1:0]   wcnt_q;
    logic               done_q;
    logic               accept;
    logic               issue;
    logic               last_iss;
    logic               last_wr;
    logic [ADDR_W-1:0]  cur_addr;
    logic [LEN_W-1:0]   cur_idx;
    logic [NBANK-1:0]   bank_free;
    logic [BANK_BITS-1:0] cur_bank;
    logic               rsp_v;
    logic [IDX_W-1:0]   rsp_idx;

    assign accept   = start && (phase_q == VL_IDLE);
    assign cur_bank = cur_addr[BANK_BITS-1:0];
    assign issue    = (phase_q == VL_ISSUE) && bank_free[cur_bank];
    assign last_iss = issue && ((cur_idx + 1'b1) == len_q);
    assign last_wr  = rsp_v && ((wcnt_q + 1'b1) == len_q);

    vld_addr_gen #(
        .ADDR_W (ADDR_W),
        .LEN_W  (LEN_W)
    ) u_agen (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (accept),
        .base   (start_base),
        .stride (start_stride),
        .adv    (issue),
        .addr   (cur_addr),
        .idx    (cur_idx)
    );

    vld_bank_timers #(
        .NBANK    (NBANK),
        .BANK_W   (BANK_BITS),
        .BUSY_CYC (BUSY_CYC)
    ) u_banks (
        .clk       (clk),
        .rst_n     (rst_n),
        .iss       (issue),
        .iss_bank  (cur_bank),
        .bank_free (bank_free)
    );

    vld_resp_pipe #(
        .RD_LAT (RD_LAT),
        .IDX_W  (IDX_W)
    ) u_rsp (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_v    (issue),
        .in_idx  (cur_idx[IDX_W-1:0]),
        .out_v   (rsp_v),
        .out_idx (rsp_idx)
    );

    // Step the load phase: idle -> issuing -> draining -> idle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            phase_q <= VL_IDLE;
        else begin
            case (phase_q)
                VL_IDLE:  if (accept && (start_len != '0)) phase_q <= VL_ISSUE;
                VL_ISSUE: if (last_iss) phase_q <= VL_DRAIN;
                VL_DRAIN: if (last_wr) phase_q <= VL_IDLE;
                default:  phase_q <= VL_IDLE;
            endcase
        end
    end

    // Latch the count and destination register of a taken command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q <= '0;
            vd_q  <= '0;
        end else if (accept) begin
            len_q <= start_len;
            vd_q  <= start_vd;
        end
    end

    // Count register writes done for the current command.
    always_ff @(posedge clk) begin
        if (!rst_n)
            wcnt_q <= '0;
        else if (accept)
            wcnt_q <= '0;
        else if (rsp_v)
            wcnt_q <= wcnt_q + 1'b1;
    end

    // Pulse completion after the last write, or at once for an empty command.
    always_ff @(posedge clk) begin
        if (!rst_n)
            done_q <= 1'b0;
        else
            done_q <= last_wr || (accept && (start_len == '0));
    end

    assign busy     = (phase_q != VL_IDLE);
    assign done     = done_q;
    assign mem_req  = issue;
    assign mem_addr = cur_addr;
    assign vr_we    = rsp_v;
    assign vr_sel   = vd_q;
    assign vr_idx   = rsp_idx;
    assign vr_wdata = mem_rdata;

    // R7: returns come back in element order
    a_r7_in_order: assert property (@(posedge clk) disable iff (!rst_n)
        vr_we |-> (LEN_W'(vr_idx) == wcnt_q));
    // R2: no write beyond the commanded count
    a_r2_write_bound: assert property (@(posedge clk) disable iff (!rst_n)
        vr_we |-> (wcnt_q < len_q));
    // R7: a write only happens inside a load
    a_r7_write_in_load: assert property (@(posedge clk) disable iff (!rst_n)
        vr_we |-> busy);
    // R8: the completion pulse lasts one cycle and finds the engine idle
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    // R9: command fields hold while a load runs
    a_r9_hold_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(len_q) && $stable(vd_q)));
endmodule

// File: tb/strided_vload_test.sv
// Scoreboard bench: the driver predicts each register write (index, word,
// cycle) from a model of the bank timers; the monitor compares at each write.
module strided_vload_test;
    localparam int AW   = 12;
    localparam int DW   = 64;
    localparam int BB   = 4;
    localparam int BUSY = 4;
    localparam int LAT  = 3;
    localparam int VMAX = 16;
    localparam int NVR  = 8;
    localparam int LW   = $clog2(VMAX + 1);
    localparam int IW   = $clog2(VMAX);
    localparam int VW   = $clog2(NVR);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [AW-1:0] start_base = '0;
    logic [AW-1:0] start_stride = '0;
    logic [LW-1:0] start_len = '0;
    logic [VW-1:0] start_vd = '0;
    logic busy, done, mem_req, vr_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_rdata, vr_wdata;
    logic [VW-1:0] vr_sel;
    logic [IW-1:0] vr_idx;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit finished = 0;

    int q_idx[$];
    int q_cyc[$];
    int q_vd[$];
    logic [DW-1:0] q_dat[$];
    int q_done[$];
    int iss_n, iss_first, iss_last, wr_n;

    strided_vload #(
        .ADDR_W(AW), .DATA_W(DW), .BANK_BITS(BB), .BUSY_CYC(BUSY),
        .RD_LAT(LAT), .VLEN_MAX(VMAX), .NUM_VREG(NVR)
    ) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .start_base(start_base),
        .start_stride(start_stride), .start_len(start_len), .start_vd(start_vd),
        .busy(busy), .done(done), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .vr_we(vr_we), .vr_sel(vr_sel), .vr_idx(vr_idx),
        .vr_wdata(vr_wdata)
    );

    always #5 clk = ~clk;

    function automatic logic [DW-1:0] mem_word(logic [AW-1:0] a);
        return {20'h5A5A5, ~a, 20'h3C3C3, a};
    endfunction

    // Memory model: fixed read latency of LAT cycles.
    logic [AW-1:0] mp [LAT];
    always @(posedge clk) begin
        mp[0] <= mem_addr;
        for (int k = 1; k < LAT; k++) mp[k] <= mp[k-1];
    end
    assign mem_rdata = mem_word(mp[LAT-1]);

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(bit ok, string tag, longint act, longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // Monitor: compare writes, completion pulses and count requests.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (mem_req) begin
                iss_n++;
                if (iss_n == 1) iss_first = cyc;
                iss_last = cyc;
            end
            if (vr_we) begin
                wr_n++;
                if (q_idx.size() == 0) begin
                    check(0, "R2 unexpected write", vr_idx, 0);
                end else begin
                    int ei, ec, ev;
                    logic [DW-1:0] ed;
                    ei = q_idx.pop_front(); ec = q_cyc.pop_front();
                    ev = q_vd.pop_front();  ed = q_dat.pop_front();
                    check(vr_idx == IW'(ei), "R7 write index", vr_idx, ei);
                    check(vr_wdata == ed, "R1 element word", vr_wdata, ed);
                    check(cyc == ec, "R3 R4 write cycle", cyc, ec);
                    check(vr_sel == VW'(ev), "R7 register select", vr_sel, ev);
                end
            end
            if (done) begin
                if (q_done.size() == 0) check(0, "R8 unexpected done", cyc, 0);
                else begin
                    int ed;
                    ed = q_done.pop_front();
                    check(cyc == ed, "R8 done cycle", cyc, ed);
                    check(!busy, "R8 busy low at done", busy, 0);
                end
            end
        end
    end

    // Driver: send one command and push the predicted writes.
    task automatic run_load(input logic [AW-1:0] base, input logic [AW-1:0] stride,
                            input int len, input int vd);
        int s, t, prev;
        int free_at [1 << BB];
        @(negedge clk);
        start = 1'b1; start_base = base; start_stride = stride;
        start_len = LW'(len); start_vd = VW'(vd);
        s = cyc; iss_n = 0; wr_n = 0; prev = 0; t = 0;
        for (int b = 0; b < (1 << BB); b++) free_at[b] = 0;
        for (int i = 0; i < len; i++) begin
            logic [AW-1:0] a;
            a = base + AW'(i) * stride;
            t = prev + 1;
            if (free_at[a[BB-1:0]] > t) t = free_at[a[BB-1:0]];
            free_at[a[BB-1:0]] = t + BUSY;
            prev = t;
            q_idx.push_back(i); q_cyc.push_back(s + t + LAT);
            q_vd.push_back(vd); q_dat.push_back(mem_word(a));
        end
        q_done.push_back(len == 0 ? s + 1 : s + t + LAT + 1);
        @(negedge clk);
        start = 1'b0;
        repeat (len * BUSY + LAT + 6) @(negedge clk);
        check(iss_n == len, "R2 request count", iss_n, len);
        check(wr_n == len, "R2 write count", wr_n, len);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10: outputs quiet under reset
        check(!busy && !done && !mem_req && !vr_we, "R10 reset state",
              {busy, done, mem_req, vr_we}, 0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done && !mem_req && !vr_we, "R10 after reset",
              {busy, done, mem_req, vr_we}, 0);

        // R6: unit stride, full rate
        run_load(12'h010, 12'h001, 16, 1);
        check(iss_last - iss_first == 15, "R6 unit stride span", iss_last - iss_first, 15);
        // R5: stride 0 paced by the bank busy time
        run_load(12'h123, 12'h000, 5, 2);
        check(iss_last - iss_first == BUSY * 4, "R5 stride 0 span", iss_last - iss_first, BUSY * 4);
        // R5: stride equal to bank count hits one bank
        run_load(12'h007, 12'h010, 16, 3);
        check(iss_last - iss_first == BUSY * 15, "R5 stride 16 span", iss_last - iss_first, BUSY * 15);
        // R3: stride 8 alternates two banks, stalls in pairs
        run_load(12'h002, 12'h008, 8, 4);
        check(iss_last - iss_first == 13, "R3 stride 8 span", iss_last - iss_first, 13);
        // R1 R6: negative odd stride wrapping below zero
        run_load(12'h005, 12'hFFD, 10, 5);
        check(iss_last - iss_first == 9, "R6 stride -3 span", iss_last - iss_first, 9);
        // R1: odd stride wrapping past the top of memory
        run_load(12'hF80, 12'h101, 12, 6);
        // R4: strides 2 and 4 touch 8 and 4 banks, no stall
        run_load(12'h001, 12'h002, 16, 7);
        check(iss_last - iss_first == 15, "R4 stride 2 span", iss_last - iss_first, 15);
        run_load(12'h003, 12'h004, 9, 0);
        check(iss_last - iss_first == 8, "R4 stride 4 span", iss_last - iss_first, 8);
        // R2: empty command
        run_load(12'h100, 12'h001, 0, 1);

        // R9: a second start during a load is ignored
        fork
            run_load(12'h200, 12'h001, 6, 2);
            begin
                repeat (3) @(negedge clk);
                start = 1'b1; start_base = 12'h777; start_stride = 12'h000;
                start_len = LW'(3); start_vd = VW'(5);
                @(negedge clk);
                start = 1'b0;
            end
        join
        check(iss_last - iss_first == 5, "R9 ignored start span", iss_last - iss_first, 5);
        repeat (BUSY * 4 + 8) @(negedge clk);
        check(!busy, "R9 no load from ignored start", busy, 0);

        check(q_idx.size() == 0, "R2 writes left over", q_idx.size(), 0);
        check(q_done.size() == 0, "R8 done left over", q_done.size(), 0);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=finish", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule